// File: doc/BRIEF.md
# Synthetic Traffic Packet Source for a Mesh Node

This block sits beside one node of an on-chip network under evaluation and feeds that node's router with artificial load. It builds fixed-length packets of 64-bit flits. Each packet starts with a header flit that names the sending node, the chosen target node and a priority value. Body flits and one closing tail flit follow the header. The target node is derived from the node's own address by a selectable rule. Three of the rules are deterministic: swap the upper and lower halves of the address, reverse its bit order, or invert every bit. The fourth rule draws a pseudo-random target from all nodes other than the sender, each equally likely.

The offered load is set by a threshold. Every cycle a free-running pseudo-random word is compared with the threshold. A new packet is started only when that word is at or below the threshold and the previous packet has been fully handed off. The output follows a valid/ready handshake, so the receiving router can stall the stream at any flit.

Top module: `noc_traffic_gen`

## Requirements
- R1: While reset is asserted and after it is released, `outValid` is low until a packet has been started, and the first packet after reset carries packet count 0.
- R2: A packet has exactly 4 flits: a header, two body flits and a tail. Bits [63:62] hold the flit kind (01 = header, 00 = body, 10 = tail). `outHead` is high only on the header and `outTail` only on the tail.
- R3: The header holds the priority in bits [61:59], the source address in [11:6] and the target address in [5:0]. All of its other bits are zero.
- R4: A body or tail flit holds its position in the packet (1, 2 or 3) in bits [9:8], and in bits [7:0] the number of packets fully sent since reset, modulo 256. All other bits apart from the kind field are zero.
- R5: With `patternSel` = 1, the target is the 6-bit source address rotated by 3 bits, so that its upper and lower halves trade places.
- R6: With `patternSel` = 2, the target is the source address with bit i moved to bit 5-i.
- R7: With `patternSel` = 3, the target is the bitwise inverse of the source address.
- R8: With `patternSel` = 0, the target is never the source address, and over a long run every one of the other 63 nodes is chosen.
- R9: A packet starts only when the injection word is at or below `rateThresh`, and never while another packet is in flight. With a threshold of zero no packet is ever sent. With an all-ones threshold and a deterministic pattern, the next header is valid on the third cycle after the previous tail is accepted.
- R10: A flit offered while `outReady` is low stays valid and unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nodeAddr | input | 6 | Address of this node, used as the source |
| patternSel | input | 2 | Target rule: 0 uniform, 1 half swap, 2 bit reverse, 3 inverse |
| prio | input | 3 | Priority copied into each header |
| rateThresh | input | 16 | Injection threshold compared with the pseudo-random word |
| outReady | input | 1 | Downstream can take the current flit |
| outValid | output | 1 | A flit is offered |
| outFlit | output | 64 | Flit contents |
| outHead | output | 1 | Offered flit is a header |
| outTail | output | 1 | Offered flit is a tail |

## Verification
The deterministic rules are run on a table of addresses. The table includes all-zeros, all-ones, alternating bits and a bit-palindrome that maps to itself. Together these addresses tell a true half swap from a plain rotation, a reversal from an identity, and an inverse from a reversal, and each packet's body flits confirm the running packet count. The uniform rule is run for thousands of packets from one address. That run shows the sender never targets itself and that no other node is starved, and it also carries the packet count through several wraps. Separate runs hold the threshold at zero, stall a header with ready low, and measure the idle gap between a tail and the next header.

// File: rtl/noc_tg_pkg.sv
package noc_tg_pkg;

  typedef enum logic [1:0] {
    PAT_UNIFORM   = 2'd0,
    PAT_TRANSPOSE = 2'd1,
    PAT_BITREV    = 2'd2,
    PAT_COMPL     = 2'd3
  } pattern_e;

  typedef enum logic [1:0] {
    KIND_BODY = 2'b00,
    KIND_HEAD = 2'b01,
    KIND_TAIL = 2'b10
  } flit_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PICK = 2'd1,
    ST_SEND = 2'd2
  } gen_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchDest;   // capture target, source and priority
    logic advFlit;     // current flit accepted downstream
    logic pktDone;     // tail accepted
  } tg_strobe_t;

endpackage

// File: rtl/tg_lfsr.sv
module tg_lfsr #(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'h0001
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [WIDTH-1:0] state
);

  logic [WIDTH-1:0] nextState;

  // Galois form, shifting right
  always_comb begin
    nextState = state >> 1;
    if (state[0]) nextState = nextState ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEED;
    else       state <= nextState;
  end

  a_r9_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);

endmodule

// File: rtl/tg_control.sv
module tg_control
  import noc_tg_pkg::*;
#(
  parameter int PKT_LEN = 4,
  localparam int IDX_W = $clog2(PKT_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             injectHit,
  input  logic             destRejected,
  input  logic             outReady,
  output tg_strobe_t       strobe,
  output logic [IDX_W-1:0] flitIdx,
  output logic             outValid,
  output logic             outHead,
  output logic             outTail
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

  gen_state_e state, stateNext;
  logic [IDX_W-1:0] idxNext;

  always_comb begin
    stateNext = state;
    idxNext   = flitIdx;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (injectHit) stateNext = ST_PICK;
      ST_PICK: begin
        if (!destRejected) begin
          strobe.latchDest = 1'b1;
          stateNext        = ST_SEND;
          idxNext          = '0;
        end
      end
      ST_SEND: begin
        if (outReady) begin
          strobe.advFlit = 1'b1;
          if (flitIdx == LAST_IDX) begin
            strobe.pktDone = 1'b1;
            stateNext      = ST_IDLE;
          end else begin
            idxNext = flitIdx + 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      flitIdx <= '0;
    end else begin
      state   <= stateNext;
      flitIdx <= idxNext;
    end
  end

  assign outValid = (state == ST_SEND);
  assign outHead  = outValid && (flitIdx == '0);
  assign outTail  = outValid && (flitIdx == LAST_IDX);

  a_r9_stay_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && !injectHit |=> state == ST_IDLE);

  a_r2_start_with_head: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outHead);

  a_r2_tail_ends_packet: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outTail |=> !outValid);

  a_r2_no_gap_inside: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outTail |=> outValid);

endmodule

// File: rtl/tg_datapath.sv
module tg_datapath
  import noc_tg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PRIO_W = 3,
  parameter int FLIT_W = 64,
  parameter int LFSR_W = 16,
  parameter int CNT_W = 8,
  parameter int PKT_LEN = 4,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] INJ_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] DST_SEED = 16'h5EED,
  localparam int IDX_W = $clog2(PKT_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] nodeAddr,
  input  logic [1:0]        patternSel,
  input  logic [PRIO_W-1:0] prio,
  input  logic [LFSR_W-1:0] rateThresh,
  input  tg_strobe_t        strobe,
  input  logic [IDX_W-1:0]  flitIdx,
  output logic              injectHit,
  output logic              destRejected,
  output logic [FLIT_W-1:0] flitData
);

  localparam int HALF_W = ADDR_W / 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

  logic [LFSR_W-1:0] injWord, dstWord;
  logic [ADDR_W-1:0] uniPick, revAddr, candidate;
  logic [ADDR_W-1:0] destQ, srcQ;
  logic [PRIO_W-1:0] prioQ;
  pattern_e          patQ;
  logic [CNT_W-1:0]  pktCnt;
  pattern_e          patIn;

  assign patIn = pattern_e'(patternSel);

  tg_lfsr #(.WIDTH(LFSR_W), .TAPS(LFSR_TAPS), .SEED(INJ_SEED)) i_injLfsr (
    .clk(clk), .rstN(rstN), .state(injWord));

  tg_lfsr #(.WIDTH(LFSR_W), .TAPS(LFSR_TAPS), .SEED(DST_SEED)) i_dstLfsr (
    .clk(clk), .rstN(rstN), .state(dstWord));

  assign injectHit = (injWord <= rateThresh);

  // fold the whole random word into an address so every bit contributes
  always_comb begin
    uniPick = '0;
    for (int i = 0; i < LFSR_W; i++) uniPick[i % ADDR_W] ^= dstWord[i];
  end

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) revAddr[i] = nodeAddr[ADDR_W-1-i];
  end

  always_comb begin
    unique case (patIn)
      PAT_TRANSPOSE: candidate = {nodeAddr[HALF_W-1:0], nodeAddr[ADDR_W-1:HALF_W]};
      PAT_BITREV:    candidate = revAddr;
      PAT_COMPL:     candidate = ~nodeAddr;
      default:       candidate = uniPick;
    endcase
  end

  assign destRejected = (patIn == PAT_UNIFORM) && (candidate == nodeAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destQ  <= '0;
      srcQ   <= '0;
      prioQ  <= '0;
      patQ   <= PAT_UNIFORM;
      pktCnt <= '0;
    end else begin
      if (strobe.latchDest) begin
        destQ <= candidate;
        srcQ  <= nodeAddr;
        prioQ <= prio;
        patQ  <= patIn;
      end
      if (strobe.pktDone) pktCnt <= pktCnt + 1'b1;
    end
  end

  always_comb begin
    flitData = '0;
    if (flitIdx == '0) begin
      flitData[FLIT_W-1 -: 2]          = KIND_HEAD;
      flitData[FLIT_W-3 -: PRIO_W]     = prioQ;
      flitData[2*ADDR_W-1 -: ADDR_W]   = srcQ;
      flitData[ADDR_W-1:0]             = destQ;
    end else begin
      flitData[FLIT_W-1 -: 2]          = (flitIdx == LAST_IDX) ? KIND_TAIL : KIND_BODY;
      flitData[CNT_W+IDX_W-1 -: IDX_W] = flitIdx;
      flitData[CNT_W-1:0]              = pktCnt;
    end
  end

  a_r8_never_self: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.latchDest) && (patQ == PAT_UNIFORM) |-> destQ != srcQ);

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pktDone |=> pktCnt == CNT_W'($past(pktCnt) + 1'b1));

  a_r4_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pktDone |=> $stable(pktCnt));

endmodule

// File: rtl/noc_traffic_gen.sv
module noc_traffic_gen
  import noc_tg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PRIO_W = 3,
  parameter int FLIT_W = 64,
  parameter int LFSR_W = 16,
  parameter int CNT_W = 8,
  parameter int PKT_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] nodeAddr,
  input  logic [1:0]        patternSel,
  input  logic [PRIO_W-1:0] prio,
  input  logic [LFSR_W-1:0] rateThresh,
  input  logic              outReady,
  output logic              outValid,
  output logic [FLIT_W-1:0] outFlit,
  output logic              outHead,
  output logic              outTail
);

  localparam int IDX_W = $clog2(PKT_LEN);

  tg_strobe_t       strobe;
  logic [IDX_W-1:0] flitIdx;
  logic             injectHit;
  logic             destRejected;

  tg_control #(.PKT_LEN(PKT_LEN)) i_control (
    .clk(clk), .rstN(rstN),
    .injectHit(injectHit), .destRejected(destRejected), .outReady(outReady),
    .strobe(strobe), .flitIdx(flitIdx),
    .outValid(outValid), .outHead(outHead), .outTail(outTail));

  tg_datapath #(
    .ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .FLIT_W(FLIT_W),
    .LFSR_W(LFSR_W), .CNT_W(CNT_W), .PKT_LEN(PKT_LEN)
  ) i_datapath (
    .clk(clk), .rstN(rstN),
    .nodeAddr(nodeAddr), .patternSel(patternSel), .prio(prio),
    .rateThresh(rateThresh), .strobe(strobe), .flitIdx(flitIdx),
    .injectHit(injectHit), .destRejected(destRejected), .flitData(outFlit));

  a_r10_hold_flit: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outFlit));

  a_r2_markers_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outHead, outTail}));

endmodule

// File: tb/test_noc_traffic_gen.sv
`timescale 1ns/1ps
module test_noc_traffic_gen;

  localparam int NODES = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  nodeAddr = '0;
  logic [1:0]  patternSel = '0;
  logic [2:0]  prio = '0;
  logic [15:0] rateThresh = '0;
  logic        rdy = 1'b1;
  logic        outValid, outHead, outTail;
  logic [63:0] outFlit;

  always #4 clk = ~clk;

  noc_traffic_gen i_noc_traffic_gen (
    .clk(clk), .rstN(rstN), .nodeAddr(nodeAddr), .patternSel(patternSel),
    .prio(prio), .rateThresh(rateThresh), .outReady(rdy),
    .outValid(outValid), .outFlit(outFlit), .outHead(outHead), .outTail(outTail));

  int tests = 0, fails = 0;
  bit finished = 0;
  logic        sValid, sHead, sTail;
  logic [63:0] sFlit;
  logic [63:0] cap [4];
  int capPos = 0, pktsDone = 0, headPktNum = 0;
  bit pktFresh = 0, tailNow = 0;

  // address, pattern, priority, expected target
  localparam logic [16:0] VEC [8] = '{
    {6'b000101, 2'd1, 3'd3, 6'b101000},
    {6'b110010, 2'd1, 3'd0, 6'b010110},
    {6'b000001, 2'd2, 3'd7, 6'b100000},
    {6'b110100, 2'd2, 3'd5, 6'b001011},
    {6'b100001, 2'd2, 3'd1, 6'b100001},
    {6'b000000, 2'd3, 3'd2, 6'b111111},
    {6'b101010, 2'd3, 3'd6, 6'b010101},
    {6'b111111, 2'd1, 3'd4, 6'b111111}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    sValid = outValid; sFlit = outFlit; sHead = outHead; sTail = outTail;
    tailNow = 0;
    if (outValid && rdy) begin
      if (outHead) begin capPos = 0; headPktNum = pktsDone; end
      if (capPos < 4) cap[capPos] = outFlit;
      capPos++;
      if (outTail) begin pktsDone++; pktFresh = 1; tailNow = 1; end
    end
  endtask

  task automatic drain();
    rateThresh = '0; rdy = 1'b1;
    repeat (30) tick();
  endtask

  function automatic logic [63:0] mkHead(logic [2:0] p, logic [5:0] s, logic [5:0] d);
    logic [63:0] f = '0;
    f[63:62] = 2'b01; f[61:59] = p; f[11:6] = s; f[5:0] = d;
    return f;
  endfunction

  function automatic logic [63:0] mkBody(int k, int n);
    logic [63:0] f = '0;
    f[63:62] = (k == 3) ? 2'b10 : 2'b00; f[9:8] = 2'(k); f[7:0] = 8'(n);
    return f;
  endfunction

  initial begin
    #(8 * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (4) tick();
    chk(sValid == 1'b0, "R1 valid low in reset", 64'(sValid), 64'd0);
    rstN = 1'b1;
    repeat (3) tick();
    chk(sValid == 1'b0, "R1 valid low after reset", 64'(sValid), 64'd0);

    // R2 R3 R4 R5 R6 R7: table walk
    for (int v = 0; v < 8; v++) begin
      logic [5:0] a, d; logic [1:0] pt; logic [2:0] pr; int n;
      {a, pt, pr, d} = VEC[v];
      drain();
      nodeAddr = a; patternSel = pt; prio = pr;
      pktFresh = 0; rateThresh = '1; n = 0;
      while (!pktFresh && n < 100) begin tick(); n++; end
      rateThresh = '0;
      if (v == 0) chk(cap[1][7:0] == 8'd0, "R1 first packet count", 64'(cap[1][7:0]), 64'd0);
      chk(cap[0] == mkHead(pr, a, d),
          pt == 2'd1 ? "R5 R3 header half swap" : pt == 2'd2 ? "R6 R3 header bit reverse" : "R7 R3 header inverse",
          cap[0], mkHead(pr, a, d));
      for (int k = 1; k < 4; k++)
        chk(cap[k] == mkBody(k, headPktNum), "R2 R4 body/tail flit", cap[k], mkBody(k, headPktNum));
    end

    // R9: threshold zero never injects
    begin
      int seen = 0;
      drain();
      repeat (300) begin tick(); if (sValid) seen++; end
      chk(seen == 0, "R9 zero threshold idle", 64'(seen), 64'd0);
    end

    // R10: header held under backpressure
    begin
      logic [63:0] f0; int n = 0; bit ok = 1;
      drain();
      nodeAddr = 6'b000101; patternSel = 2'd1; prio = 3'd6;
      rdy = 1'b0; rateThresh = '1;
      while (!sValid && n < 50) begin tick(); n++; end
      f0 = sFlit;
      chk(sHead == 1'b1, "R10 stalled flit is header", 64'(sHead), 64'd1);
      repeat (6) begin tick(); if (!(sValid && sFlit == f0)) ok = 0; end
      chk(ok, "R10 held stable", sFlit, f0);
      rateThresh = '0; rdy = 1'b1;
      drain();
    end

    // R9: gap from accepted tail to next header
    begin
      int n = 0, k = 0;
      nodeAddr = 6'd0; patternSel = 2'd3; prio = 3'd0;
      rateThresh = '1; rdy = 1'b1;
      tailNow = 0;
      while (!tailNow && n < 50) begin tick(); n++; end
      do begin tick(); k++; end while (!sValid && k < 10);
      chk(k == 3 && sHead, "R9 tail-to-head gap", 64'(k), 64'd3);
      drain();
    end

    // R8 R4: uniform targets over a long run
    begin
      bit hit [NODES];
      int selfHits = 0, missing = 0, badCnt = 0, badSrc = 0, n = 0, start;
      logic [5:0] me = 6'd37;
      for (int i = 0; i < NODES; i++) hit[i] = 0;
      nodeAddr = me; patternSel = 2'd0; prio = 3'd1;
      start = pktsDone;
      rateThresh = '1; rdy = 1'b1;
      while (pktsDone - start < 3000 && n < 40000) begin
        tick(); n++;
        if (tailNow) begin
          if (cap[0][5:0] == me) selfHits++;
          hit[cap[0][5:0]] = 1;
          if (cap[0][11:6] != me) badSrc++;
          if (cap[3] != mkBody(3, headPktNum)) badCnt++;
        end
      end
      rateThresh = '0;
      for (int i = 0; i < NODES; i++) if (i != me && !hit[i]) missing++;
      chk(selfHits == 0, "R8 no self target", 64'(selfHits), 64'd0);
      chk(missing == 0, "R8 all other nodes reached", 64'(missing), 64'd0);
      chk(badSrc == 0, "R3 uniform header source", 64'(badSrc), 64'd0);
      chk(badCnt == 0, "R4 count through wrap", 64'(badCnt), 64'd0);
      chk(pktsDone - start >= 3000, "R8 run completed", 64'(pktsDone - start), 64'd3000);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule